// File: doc/BRIEF.md
# Floating-Point Register Stack Load Unit

This block holds a circular stack of 80-bit extended-precision floating-point values. The stack is addressed relative to a top-of-stack pointer, and each entry carries a tag that says whether it is empty or valid. The block takes an opcode byte and a ModRM byte with a request strobe and decodes them. A recognised load pushes one new value. That value comes either from the memory data input, which is already converted to 80 bits, or from another stack entry ST(i) chosen by the low three ModRM bits.

Every push moves the pointer down by one entry, with wraparound, and writes the new value into the entry that becomes ST(0). A register-sourced push reads its source relative to the old top, before the pointer moves, so ST(0) as the source copies the current top. When the push would land on an occupied entry (overflow) or would read an empty one (underflow), the block writes the quiet-NaN indefinite value and raises a one-cycle stack-fault output. The C1 condition flag tells overflow apart from underflow.

Top module: `fpstk_load`

## Requirements
- R1: After synchronous reset, the top pointer is 0, every entry is tagged empty (st0_valid = 0), and c1, stack_fault and src_fmt are all 0.
- R2: A memory push decrements the top pointer by one modulo DEPTH and makes st0_val equal to mem_val, with st0_valid = 1 from the cycle after the request.
- R3: Decode with src_fmt encoding 0 = register, 1 = 32-bit memory, 2 = 64-bit memory, 3 = 80-bit memory. The forms are: opcode D9 with ModRM mod != 3 and reg = 0 gives 1; DD with mod != 3 and reg = 0 gives 2; DB with mod != 3 and reg = 5 gives 3; D9 with ModRM C0..C7 gives 0, with index = ModRM[2:0].
- R4: Any other opcode/ModRM pair, and any cycle with req low, leaves top, the stack contents, c1 and src_fmt unchanged.
- R5: A register push reads ST(i) at entry (old top + i) before the decrement, so index 0 duplicates the old top value.
- R6: A push whose target entry (old top − 1) is already valid sets c1 = 1 and stack_fault = 1, and the new ST(0) holds the indefinite value FFFF_C000_0000_0000_0000 (hex), tagged valid.
- R7: A push without overflow drives c1 to 0.
- R8: A register push whose source entry is empty, with no overflow, gives stack_fault = 1, c1 = 0 and the indefinite value in ST(0).
- R9: stack_fault is high only in the cycle after a faulting push and low in every other cycle.
- R10: The top pointer wraps from 0 to DEPTH − 1 on a push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Instruction present this cycle |
| opc | input | 8 | Opcode byte |
| modrm | input | 8 | ModRM byte |
| mem_val | input | 80 | Memory operand, already in 80-bit format |
| top_idx | output | $clog2(DEPTH) | Current top-of-stack pointer |
| st0_val | output | 80 | Value in ST(0) |
| st0_valid | output | 1 | Tag of ST(0) |
| c1 | output | 1 | Condition flag C1 from the last push |
| stack_fault | output | 1 | Stack overflow/underflow pulse |
| src_fmt | output | 2 | Source format of the last push |

## Verification
The bench builds the block with the default DEPTH of 8, so the stack fills after eight pushes. With that depth, a single run of the vector table covers the pointer wrapping from 0 to 7, the first overflow onto an occupied entry, and an underflow from an index that points at an empty entry. A reset followed by a directed fill repeats the full-stack case from a known empty state, with both source kinds.

// File: rtl/fpstk_pkg.sv
package fpstk_pkg;
    timeunit 1ns; timeprecision 1ps;

    localparam int VAL_W = 80;
    localparam int IDX_W = 3;

    typedef logic [VAL_W-1:0] fpval_t;

    typedef enum logic [1:0] {
        SRC_REG = 2'd0,
        SRC_SGL = 2'd1,
        SRC_DBL = 2'd2,
        SRC_EXT = 2'd3
    } src_fmt_e;

    typedef struct packed {
        logic             push;
        src_fmt_e         fmt;
        logic [IDX_W-1:0] idx;
    } ld_op_t;

    // Quiet-NaN indefinite: sign set, exponent all ones, integer and quiet bits set
    localparam fpval_t INDEF = {1'b1, 15'h7FFF, 2'b11, 62'd0};

    function automatic ld_op_t decode_ld(input logic [7:0] opc, input logic [7:0] modrm);
        ld_op_t     r;
        logic       regform;
        logic [2:0] rfield;
        r       = '0;
        r.fmt   = SRC_REG;
        regform = (modrm[7:6] == 2'b11);
        rfield  = modrm[5:3];
        case (opc)
            8'hD9: if (rfield == 3'd0) begin
                r.push = 1'b1;
                r.fmt  = regform ? SRC_REG : SRC_SGL;
                r.idx  = regform ? modrm[2:0] : 3'd0;
            end
            8'hDD: if (!regform && rfield == 3'd0) begin
                r.push = 1'b1;
                r.fmt  = SRC_DBL;
            end
            8'hDB: if (!regform && rfield == 3'd5) begin
                r.push = 1'b1;
                r.fmt  = SRC_EXT;
            end
            default: ;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/fpstk_decode.sv
module fpstk_decode
    import fpstk_pkg::*;
(
    input  logic       req,
    input  logic [7:0] opc,
    input  logic [7:0] modrm,
    output ld_op_t     op
);
    timeunit 1ns; timeprecision 1ps;

    ld_op_t raw;

    always_comb begin
        raw     = decode_ld(opc, modrm);
        op      = raw;
        op.push = raw.push & req;
    end
endmodule

// File: rtl/fpstk_regfile.sv
module fpstk_regfile
    import fpstk_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [PTR_W-1:0] wr_pos,
    input  fpval_t           wr_val,
    input  logic [PTR_W-1:0] rd_a_pos,
    output fpval_t           rd_a_val,
    output logic             rd_a_tag,
    input  logic [PTR_W-1:0] rd_b_pos,
    output fpval_t           rd_b_val,
    output logic             rd_b_tag,
    input  logic [PTR_W-1:0] probe_pos,
    output logic             probe_tag
);
    timeunit 1ns; timeprecision 1ps;

    fpval_t             data_w [DEPTH];
    logic   [DEPTH-1:0] tag_w;

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_ent
            fpval_t d_q;
            logic   t_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    d_q <= '0;
                    t_q <= 1'b0;
                end else if (wr_en && wr_pos == PTR_W'(e)) begin
                    d_q <= wr_val;
                    t_q <= 1'b1;
                end
            end
            assign data_w[e] = d_q;
            assign tag_w[e]  = t_q;
        end
    endgenerate

    assign rd_a_val  = data_w[rd_a_pos];
    assign rd_a_tag  = tag_w[rd_a_pos];
    assign rd_b_val  = data_w[rd_b_pos];
    assign rd_b_tag  = tag_w[rd_b_pos];
    assign probe_tag = tag_w[probe_pos];

    // R2
    written_tag_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> tag_w[$past(wr_pos)]);
endmodule

// File: rtl/fpstk_load.sv
module fpstk_load
    import fpstk_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req,
    input  logic [7:0]       opc,
    input  logic [7:0]       modrm,
    input  logic [79:0]      mem_val,
    output logic [PTR_W-1:0] top_idx,
    output logic [79:0]      st0_val,
    output logic             st0_valid,
    output logic             c1,
    output logic             stack_fault,
    output logic [1:0]       src_fmt
);
    timeunit 1ns; timeprecision 1ps;

    typedef logic [PTR_W-1:0] ptr_t;

    ld_op_t   op;
    ptr_t     top_q, new_top, src_pos;
    logic     c1_q, flt_q;
    src_fmt_e fmt_q;
    fpval_t   src_val, wr_val;
    logic     src_tag, tgt_tag, ovf, unf, fault;

    fpstk_decode u_dec (
        .req   (req),
        .opc   (opc),
        .modrm (modrm),
        .op    (op)
    );

    always_comb begin
        new_top = top_q - 1'b1;
        src_pos = top_q + ptr_t'(op.idx);
        ovf     = tgt_tag;
        unf     = (op.fmt == SRC_REG) && !src_tag;
        fault   = ovf | unf;
        if (fault)                 wr_val = INDEF;
        else if (op.fmt == SRC_REG) wr_val = src_val;
        else                       wr_val = mem_val;
    end

    fpstk_regfile #(.DEPTH(DEPTH)) u_rf (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (op.push),
        .wr_pos    (new_top),
        .wr_val    (wr_val),
        .rd_a_pos  (top_q),
        .rd_a_val  (st0_val),
        .rd_a_tag  (st0_valid),
        .rd_b_pos  (src_pos),
        .rd_b_val  (src_val),
        .rd_b_tag  (src_tag),
        .probe_pos (new_top),
        .probe_tag (tgt_tag)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q <= '0;
            c1_q  <= 1'b0;
            flt_q <= 1'b0;
            fmt_q <= SRC_REG;
        end else begin
            flt_q <= op.push & fault;
            if (op.push) begin
                top_q <= new_top;
                c1_q  <= ovf;
                fmt_q <= op.fmt;
            end
        end
    end

    assign top_idx     = top_q;
    assign c1          = c1_q;
    assign stack_fault = flt_q;
    assign src_fmt     = fmt_q;

    // R2
    top_dec_chk: assert property (@(posedge clk) disable iff (rst)
        op.push |=> top_q == ptr_t'($past(top_q) - 1'b1));
    // R4
    top_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !op.push |=> $stable(top_q));
    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (op.push && tgt_tag) |=> (c1 && stack_fault && st0_val == INDEF));
    // R7
    c1_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (op.push && !tgt_tag) |=> !c1);
    // R9
    fault_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !op.push |=> !stack_fault);
endmodule

// File: tb/sim_fpstk_load.sv
module sim_fpstk_load;
    timeunit 1ns; timeprecision 1ps;

    localparam logic [79:0] IND = 80'hFFFF_C000_0000_0000_0000;
    localparam logic [79:0] A1  = 80'h3FFF_8000_0000_0000_0001;
    localparam logic [79:0] A2  = 80'h4000_C000_0000_0000_0002;
    localparam logic [79:0] A3  = 80'hC001_A000_0000_0000_0003;
    localparam logic [79:0] A4  = 80'h3FFE_9000_0000_0000_0004;
    localparam logic [79:0] A5  = 80'h4005_F000_0000_0000_0005;
    localparam logic [79:0] A6  = 80'h0000_0000_0000_0000_0006;

    typedef struct packed {
        logic [7:0]  opc;
        logic [7:0]  modrm;
        logic [79:0] data;
        logic [2:0]  e_top;
        logic [79:0] e_st0;
        logic        e_vld;
        logic        e_c1;
        logic        e_flt;
        logic [1:0]  e_fmt;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{8'hD9, 8'h00, A1, 3'd7, A1,  1'b1, 1'b0, 1'b0, 2'd1}, // R2 R3 R7 R10
        '{8'hDD, 8'h05, A2, 3'd6, A2,  1'b1, 1'b0, 1'b0, 2'd2}, // R3
        '{8'hDB, 8'h28, A3, 3'd5, A3,  1'b1, 1'b0, 1'b0, 2'd3}, // R3
        '{8'hD9, 8'hC2, A6, 3'd4, A1,  1'b1, 1'b0, 1'b0, 2'd0}, // R5 ST(2)
        '{8'hD9, 8'hC1, A6, 3'd3, A3,  1'b1, 1'b0, 1'b0, 2'd0}, // R5 ST(1)
        '{8'hD9, 8'hC0, A6, 3'd2, A3,  1'b1, 1'b0, 1'b0, 2'd0}, // R5 duplicate
        '{8'hDD, 8'h10, A6, 3'd2, A3,  1'b1, 1'b0, 1'b0, 2'd0}, // R4 not a load
        '{8'hD9, 8'hE8, A6, 3'd2, A3,  1'b1, 1'b0, 1'b0, 2'd0}, // R4 not a load
        '{8'hD9, 8'hC7, A6, 3'd1, IND, 1'b1, 1'b0, 1'b1, 2'd0}, // R8 underflow
        '{8'hDB, 8'h68, A4, 3'd0, A4,  1'b1, 1'b0, 1'b0, 2'd3}, // R9 fault drops
        '{8'hD9, 8'h00, A5, 3'd7, IND, 1'b1, 1'b1, 1'b1, 2'd1}, // R6 R10
        '{8'hDB, 8'h2B, A6, 3'd6, IND, 1'b1, 1'b1, 1'b1, 2'd3}, // R6
        '{8'hDB, 8'hE8, A6, 3'd6, IND, 1'b1, 1'b1, 1'b0, 2'd3}  // R4 R9
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0;
    logic [7:0]  opc = 8'h00;
    logic [7:0]  modrm = 8'h00;
    logic [79:0] mem_val = '0;
    logic [2:0]  top_idx;
    logic [79:0] st0_val;
    logic        st0_valid, c1, stack_fault;
    logic [1:0]  src_fmt;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fpstk_load u0 (
        .clk(clk), .rst(rst), .req(req), .opc(opc), .modrm(modrm), .mem_val(mem_val),
        .top_idx(top_idx), .st0_val(st0_val), .st0_valid(st0_valid), .c1(c1),
        .stack_fault(stack_fault), .src_fmt(src_fmt)
    );

    task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag, input logic [2:0] t, input logic [79:0] v,
                             input logic vl, input logic c, input logic f, input logic [1:0] fm);
        chk({tag, " top"}, 80'(top_idx), 80'(t));
        chk({tag, " st0"}, st0_val, v);
        chk({tag, " valid"}, 80'(st0_valid), 80'(vl));
        chk({tag, " c1"}, 80'(c1), 80'(c));
        chk({tag, " fault"}, 80'(stack_fault), 80'(f));
        chk({tag, " fmt"}, 80'(src_fmt), 80'(fm));
    endtask

    task automatic push(input logic [7:0] o, input logic [7:0] m, input logic [79:0] d);
        @(negedge clk);
        req = 1'b1; opc = o; modrm = m; mem_val = d;
        @(negedge clk);
        req = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 200000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_all("R1 reset", 3'd0, 80'd0, 1'b0, 1'b0, 1'b0, 2'd0);

        foreach (VECS[k]) begin
            push(VECS[k].opc, VECS[k].modrm, VECS[k].data);
            check_all($sformatf("vec%0d R2-R10", k), VECS[k].e_top, VECS[k].e_st0,
                      VECS[k].e_vld, VECS[k].e_c1, VECS[k].e_flt, VECS[k].e_fmt);
        end

        // R1 reset again from a full, faulted stack
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_all("R1 re-reset", 3'd0, 80'd0, 1'b0, 1'b0, 1'b0, 2'd0);

        // R4 valid load encoding with req low
        @(negedge clk); opc = 8'hD9; modrm = 8'h00; mem_val = A1;
        @(negedge clk);
        check_all("R4 req low", 3'd0, 80'd0, 1'b0, 1'b0, 1'b0, 2'd0);

        // R8 duplicate of an empty top
        push(8'hD9, 8'hC0, A2);
        check_all("R8 empty ST0", 3'd7, IND, 1'b1, 1'b0, 1'b1, 2'd0);

        // R2 fill remaining seven entries from memory
        for (int n = 1; n < 8; n++) begin
            push(8'hDD, 8'h45, A2 + 80'(n));
            check_all("R2 fill", 3'(7 - n), A2 + 80'(n), 1'b1, 1'b0, 1'b0, 2'd2);
        end

        // R6 register push onto a full stack
        push(8'hD9, 8'hC3, A3);
        check_all("R6 full reg push", 3'd7, IND, 1'b1, 1'b1, 1'b1, 2'd0);

        // R9 fault low in the idle cycle after
        @(negedge clk);
        chk("R9 idle fault", 80'(stack_fault), 80'd0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule